// File: doc/BRIEF.md
# Synchronous Serial Shift Interface

This block moves 8-bit or 16-bit words across a three-wire synchronous serial link. It can drive the link as master or follow it as slave. A processor reaches it through a small register port with three word-wide locations: data, control and status. Writing the data location loads a transmit holding register. Reading it returns the read buffer, which holds the last word received. A transfer shifts a single register most-significant bit first. On completion, the received word is copied into the read buffer, so the next word can shift while software collects the previous one.

In master mode the block makes the serial clock from the system clock with a programmable divider. A transfer starts as soon as the holding register holds a word. In slave mode the block follows an external clock and a chip select that is active low. Both are synchronised into the system clock domain. A slave frame starts when chip select goes low. If no new word was written, the frame sends either the read-buffer contents (echo enabled) or zeros. Control bits choose the idle clock level, normal or swapped data edges, the frame width and the interrupt enable. An interrupt line reports that a received word is waiting.

Register map: address 0 is data, address 1 is control, address 2 is status. Control bits: [7:0] divider value D, [8] idle level high, [9] swapped edges, [10] 16-bit frame, [11] echo, [12] master, [13] interrupt enable. Status bits: [0] busy, [1] read-buffer full, [2] overrun.

Top module: `mw_serial_if`

## Requirements
- R1: After reset, the control and status locations read 0, the interrupt line is low, and the serial clock output and the data output are low.
- R2: In master mode, writing the data location starts a frame. The frame has exactly 2N serial clock edges, where N is 16 or 8. Consecutive edges are D+1 system clock cycles apart.
- R3: Data leaves the serial output most-significant bit first. The bits sampled on the serial input are assembled most-significant bit first and stored in the read buffer at the end of the frame.
- R4: With control bit 9 clear, the serial output changes only on falling clock edges and the input is sampled on rising edges. With bit 9 set, the two edges swap roles.
- R5: Between master frames, the serial clock output rests at the level given by control bit 8, and it returns to that level after the last edge of a frame.
- R6: With control bit 10 clear, a frame shifts only the low 8 bits of the written word, and the read buffer's upper 8 bits read 0.
- R7: Status bit 0 is set while a frame is in progress. Status bit 1 is set when a frame completes and is cleared by reading the data location.
- R8: Status bit 2 is set when a frame completes while status bit 1 is still set. It is cleared by reading the status location, and that read still returns the set value.
- R9: The interrupt line is high exactly while status bit 1 and control bit 13 are both set.
- R10: In slave mode, a frame advances only while chip select is low. Raising chip select before the last edge abandons the frame and leaves the read buffer and status bit 1 unchanged. Clock edges seen while chip select is high have no effect.
- R11: A slave frame that starts without a newly written word sends the current read-buffer contents when control bit 11 is set, and zeros when it is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register location: 0 data, 1 control, 2 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt request: received word waiting |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| cs_n | input | 1 | Slave chip select, active low |

## Verification
The most likely corrupted state is the edge counter or the edge-role decision. Either shows up within a single frame as a wrong edge count, a clock left at the wrong level, or a word captured at the far end that is shifted by one bit. A read buffer or full flag that is updated at the wrong time shows as a wrong data read, a wrong status bit or a wrong interrupt level at the next register access after the frame. A slave frame that is not abandoned correctly, or a wrong echo source, becomes visible as soon as the next slave frame's output word is captured.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int DIV_W = 8;

  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_CTRL = 2'd1,
    A_STAT = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic             irq_en;
    logic             master;
    logic             echo;
    logic             wide;
    logic             alt_edge;
    logic             idle_hi;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int STAT_W = 3;
endpackage

// File: rtl/mw_edge_src.sv
module mw_edge_src #(
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic             run,
  input  logic             idle_hi,
  input  logic [DIV_W-1:0] div,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             edge_p,
  output logic             edge_rise
);
  localparam int SH_W = SYNC_N + 1;

  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic [SH_W-1:0]  sync_q;
  logic             tick;

  assign tick = master && run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SH_W-2:0], sclk_i};
      if (master && run) begin
        if (tick) begin
          cnt_q  <= '0;
          sclk_q <= ~sclk_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q  <= '0;
        sclk_q <= idle_hi;
      end
    end
  end

  always_comb begin
    if (master) begin
      edge_p    = tick;
      edge_rise = ~sclk_q;
    end else begin
      edge_p    = sync_q[SH_W-1] ^ sync_q[SH_W-2];
      edge_rise = sync_q[SH_W-2] & ~sync_q[SH_W-1];
    end
  end

  assign sclk_o = sclk_q;

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (master && $past(master) && $past(tick) && div != '0 && $stable(div)) |-> !tick);
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              wide,
  input  logic              alt_edge,
  input  logic              abort,
  input  logic              edge_p,
  input  logic              edge_rise,
  input  logic              sdi,
  output logic              busy,
  output logic              sdo,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int HALF  = DATA_W / 2;
  localparam int CNT_W = $clog2(2 * DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2 * DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  ecnt_q;
  logic              busy_q, dout_q, done_q;
  logic [CNT_W-1:0]  last_edge;
  logic              sr_top, tx_top, sample_edge;
  logic [DATA_W-1:0] tx_masked;

  assign last_edge   = wide ? LAST_WIDE : LAST_NARROW;
  assign sr_top      = wide ? sr_q[DATA_W-1] : sr_q[HALF-1];
  assign tx_top      = wide ? tx_word[DATA_W-1] : tx_word[HALF-1];
  assign tx_masked   = wide ? tx_word : {{(DATA_W-HALF){1'b0}}, tx_word[HALF-1:0]};
  assign sample_edge = edge_rise ^ alt_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      ecnt_q <= '0;
      busy_q <= 1'b0;
      dout_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        sr_q   <= tx_masked;
        dout_q <= tx_top;
        busy_q <= 1'b1;
        ecnt_q <= '0;
      end else if (busy_q && abort) begin
        busy_q <= 1'b0;
      end else if (busy_q && edge_p) begin
        ecnt_q <= ecnt_q + 1'b1;
        if (sample_edge) begin
          sr_q <= {sr_q[DATA_W-2:0], sdi};
        end else if (ecnt_q != last_edge) begin
          dout_q <= sr_top;
        end
        if (ecnt_q == last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sdo     = dout_q;
  assign done    = done_q;
  assign rx_word = wide ? sr_q : {{(DATA_W-HALF){1'b0}}, sr_q[HALF-1:0]};

  // R2
  edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (ecnt_q <= last_edge));

  // R4
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_q && !abort && edge_p && (edge_rise ^ alt_edge)) && !$past(start && !busy_q))
      |-> $stable(dout_q));
endmodule

// File: rtl/mw_regs.sv
module mw_regs
  import mw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              busy,
  input  logic              tx_take,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_valid,
  output logic [DATA_W-1:0] rbuf,
  output logic              irq
);
  ctrl_t             ctrl_q, ctrl_n;
  logic [DATA_W-1:0] txw_q, txw_n, rbuf_q, rbuf_n, rdata_q;
  logic              txv_q, txv_n, rbf_q, rbf_n, ovr_q, ovr_n, irq_q;
  logic              rd_data, rd_stat;

  assign rd_data = rd_en && (addr == A_DATA);
  assign rd_stat = rd_en && (addr == A_STAT);

  always_comb begin
    ctrl_n = ctrl_q;
    txw_n  = txw_q;
    txv_n  = txv_q;
    rbuf_n = rbuf_q;
    rbf_n  = rbf_q;
    ovr_n  = ovr_q;
    if (tx_take) txv_n = 1'b0;
    if (wr_en) begin
      case (addr)
        A_DATA: begin
          txw_n = wdata;
          txv_n = 1'b1;
        end
        A_CTRL:  ctrl_n = ctrl_t'(wdata[CTRL_W-1:0]);
        default: ;
      endcase
    end
    if (rd_data) rbf_n = 1'b0;
    if (rd_stat) ovr_n = 1'b0;
    if (done) begin
      rbuf_n = rx_word;
      if (rbf_q && !rd_data) ovr_n = 1'b1;
      rbf_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      txw_q   <= '0;
      txv_q   <= 1'b0;
      rbuf_q  <= '0;
      rbf_q   <= 1'b0;
      ovr_q   <= 1'b0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      txw_q  <= txw_n;
      txv_q  <= txv_n;
      rbuf_q <= rbuf_n;
      rbf_q  <= rbf_n;
      ovr_q  <= ovr_n;
      irq_q  <= rbf_n & ctrl_n.irq_en;
      if (rd_en) begin
        case (addr)
          A_DATA:  rdata_q <= rbuf_q;
          A_CTRL:  rdata_q <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
          A_STAT:  rdata_q <= {{(DATA_W-STAT_W){1'b0}}, ovr_q, rbf_q, busy};
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign ctrl     = ctrl_q;
  assign tx_word  = txw_q;
  assign tx_valid = txv_q;
  assign rbuf     = rbuf_q;
  assign rdata    = rdata_q;
  assign irq      = irq_q;

  // R8
  ovr_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(done && rbf_q));

  // R7
  rbf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rbf_q) |-> $past(rd_en && addr == A_DATA));

  // R9
  irq_rbf_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> rbf_q);
endmodule

// File: rtl/mw_serial_if.sv
module mw_serial_if
  import mw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sclk_o,
  input  logic              sclk_i,
  input  logic              sdi,
  output logic              sdo,
  input  logic              cs_n
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] tx_word, rbuf, rx_word, load_word;
  logic              tx_valid, busy, done, edge_p, edge_rise;
  logic              start_req, tx_take, abort, cs_low;
  logic [SYNC_N-1:0] cs_sync_q;

  always_ff @(posedge clk) begin
    if (rst) cs_sync_q <= '1;
    else     cs_sync_q <= {cs_sync_q[SYNC_N-2:0], cs_n};
  end

  assign cs_low    = ~cs_sync_q[SYNC_N-1];
  assign start_req = ctrl.master ? tx_valid : cs_low;
  assign tx_take   = start_req && !busy && tx_valid;
  assign abort     = !ctrl.master && !cs_low;
  assign load_word = tx_valid ? tx_word : (ctrl.echo ? rbuf : '0);

  mw_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .done(done), .rx_word(rx_word),
    .busy(busy), .tx_take(tx_take), .ctrl(ctrl), .tx_word(tx_word),
    .tx_valid(tx_valid), .rbuf(rbuf), .irq(irq)
  );

  mw_edge_src #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst(rst), .master(ctrl.master), .run(busy),
    .idle_hi(ctrl.idle_hi), .div(ctrl.div), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .edge_p(edge_p), .edge_rise(edge_rise)
  );

  mw_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .start(start_req), .tx_word(load_word),
    .wide(ctrl.wide), .alt_edge(ctrl.alt_edge), .abort(abort),
    .edge_p(edge_p), .edge_rise(edge_rise), .sdi(sdi), .busy(busy),
    .sdo(sdo), .done(done), .rx_word(rx_word)
  );

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.master && !busy && $past(ctrl.master && !busy) && $stable(ctrl.idle_hi))
      |-> (sclk_o == ctrl.idle_hi));

  // R10
  slave_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.master && $past(!ctrl.master && !cs_low && busy)) |-> !busy);
endmodule

// File: tb/tb_mw_serial_if.sv
`timescale 1ns/1ps
module tb_mw_serial_if;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic        idle;
    logic        alt;
    logic        wide;
    logic [7:0]  div;
    logic [15:0] tx;
    logic [15:0] pat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 8'd0, 16'hA5C3, 16'h3C5A},
    '{1'b1, 1'b0, 1'b1, 8'd1, 16'h8001, 16'h7FFE},
    '{1'b0, 1'b1, 1'b1, 8'd2, 16'h1234, 16'hFEDC},
    '{1'b1, 1'b1, 1'b0, 8'd0, 16'h12C7, 16'h9A5E},
    '{1'b0, 1'b0, 1'b0, 8'd3, 16'h00FF, 16'h0081},
    '{1'b1, 1'b1, 1'b1, 8'd1, 16'hFFFF, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic irq, sclk_o, sdo;
  logic sclk_i = 1'b0;
  logic cs_n = 1'b1;
  logic sdi, sdi_mdl, sdi_tsk;

  int checks = 0, errors = 0;
  int cyc = 0;

  // bench-side slave model for master frames
  logic mdl_on = 1'b0;
  logic mdl_alt = 1'b0;
  logic mdl_wide = 1'b1;
  logic [15:0] mdl_pat = '0, mdl_cap = '0;
  logic [7:0] mdl_div = '0;
  int mdl_idx = 0, mdl_edges = 0, mdl_last = 0, mdl_gap_bad = 0;

  assign sdi = mdl_on ? sdi_mdl : sdi_tsk;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  mw_serial_if #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk_o(sclk_o),
    .sclk_i(sclk_i), .sdi(sdi), .sdo(sdo), .cs_n(cs_n)
  );

  always @(posedge sclk_o or negedge sclk_o) begin
    if (mdl_on) begin
      int n;
      n = mdl_wide ? 16 : 8;
      if (mdl_edges > 0 && (cyc - mdl_last) != int'(mdl_div) + 1) mdl_gap_bad++;
      mdl_last = cyc;
      mdl_edges++;
      if (sclk_o ^ mdl_alt) begin
        mdl_cap = {mdl_cap[14:0], sdo};
        mdl_idx++;
      end else if (mdl_idx < n) begin
        sdi_mdl = mdl_pat[n-1-mdl_idx];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic arm_model(input logic wide, input logic alt, input logic [7:0] div,
                           input logic [15:0] pat);
    mdl_wide = wide; mdl_alt = alt; mdl_div = div; mdl_pat = pat;
    mdl_cap = '0; mdl_idx = 0; mdl_edges = 0; mdl_gap_bad = 0;
    sdi_mdl = wide ? pat[15] : pat[7];
    mdl_on = 1'b1;
  endtask

  task automatic wait_frame(input logic wide);
    int n2;
    n2 = wide ? 32 : 16;
    for (int k = 0; k < 4000 && mdl_edges < n2; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic master_frame(input logic [15:0] ctrlw, input logic [15:0] tx,
                              input logic [15:0] pat);
    mdl_on = 1'b0;
    reg_write(2'd1, ctrlw);
    repeat (2) @(negedge clk);
    arm_model(ctrlw[10], ctrlw[9], ctrlw[7:0], pat);
    reg_write(2'd0, tx);
    wait_frame(ctrlw[10]);
  endtask

  // bench acts as master: idle low, normal edges, 16-bit
  task automatic slave_frame(input logic [15:0] pat, input int nbits, output logic [15:0] cap);
    cap = '0;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi_tsk = pat[15-i];
      repeat (8) @(negedge clk);
      sclk_i = 1'b1;
      cap = {cap[14:0], sdo};
      repeat (8) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] rd, cap, exp_tx, exp_rx, cw;
    sdi_tsk = 1'b0;
    sdi_mdl = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 sclk_o", 32'(sclk_o), 32'd0);
    check("R1 sdo", 32'(sdo), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    reg_read(2'd1, rd); check("R1 ctrl", 32'(rd), 32'd0);
    reg_read(2'd2, rd); check("R1 status", 32'(rd), 32'd0);

    // vector walk: master frames over edge modes, idle levels, widths, dividers
    for (int v = 0; v < NV; v++) begin
      cw = {2'b00, 1'b0, 1'b1, 1'b0, VECS[v].wide, VECS[v].alt, VECS[v].idle, VECS[v].div};
      exp_tx = VECS[v].wide ? VECS[v].tx  : {8'h00, VECS[v].tx[7:0]};
      exp_rx = VECS[v].wide ? VECS[v].pat : {8'h00, VECS[v].pat[7:0]};
      mdl_on = 1'b0;
      reg_write(2'd1, cw);
      repeat (2) @(negedge clk);
      arm_model(VECS[v].wide, VECS[v].alt, VECS[v].div, VECS[v].pat);
      reg_write(2'd0, VECS[v].tx);
      @(negedge clk);
      reg_read(2'd2, rd);
      check("R7 busy during frame", 32'(rd[0]), 32'd1);
      wait_frame(VECS[v].wide);
      check("R2 edge count", 32'(mdl_edges), VECS[v].wide ? 32'd32 : 32'd16);
      check("R2 half period", 32'(mdl_gap_bad), 32'd0);
      check("R5 idle level after frame", 32'(sclk_o), 32'(VECS[v].idle));
      check("R4 R6 word seen on sdo", 32'(mdl_cap), 32'(exp_tx));
      reg_read(2'd2, rd);
      check("R7 status after frame", 32'(rd), 32'h2);
      reg_read(2'd0, rd);
      check("R3 R6 read buffer", 32'(rd), 32'(exp_rx));
      reg_read(2'd2, rd);
      check("R7 full cleared by data read", 32'(rd), 32'h0);
    end

    // R9 interrupt with enable set
    master_frame(16'h3401, 16'h5A5A, 16'hC0DE);
    check("R9 irq raised", 32'(irq), 32'd1);
    reg_read(2'd0, rd);
    check("R3 read buffer", 32'(rd), 32'h0000C0DE);
    check("R9 irq cleared by read", 32'(irq), 32'd0);

    // R9 enable clear, then R8 overrun
    master_frame(16'h1401, 16'h0F0F, 16'h1111);
    check("R9 irq masked", 32'(irq), 32'd0);
    reg_read(2'd2, rd);
    check("R7 full set", 32'(rd), 32'h2);
    master_frame(16'h1401, 16'hF0F0, 16'h2222);
    reg_read(2'd2, rd);
    check("R8 overrun set", 32'(rd), 32'h6);
    reg_read(2'd2, rd);
    check("R8 overrun cleared by status read", 32'(rd), 32'h2);
    reg_read(2'd0, rd);
    check("R8 newest word kept", 32'(rd), 32'h2222);
    mdl_on = 1'b0;

    // slave mode: 16-bit, echo on
    reg_write(2'd1, 16'h0C00);
    repeat (4) @(negedge clk);
    reg_write(2'd0, 16'hBEEF);
    slave_frame(16'h1357, 16, cap);
    check("R10 slave sends written word", 32'(cap), 32'hBEEF);
    reg_read(2'd0, rd);
    check("R3 slave read buffer", 32'(rd), 32'h1357);
    slave_frame(16'h2468, 16, cap);
    check("R11 echo of read buffer", 32'(cap), 32'h1357);
    reg_read(2'd0, rd);
    check("R3 slave second word", 32'(rd), 32'h2468);
    reg_write(2'd1, 16'h0400);
    repeat (4) @(negedge clk);
    slave_frame(16'h0F0F, 16, cap);
    check("R11 zeros without echo", 32'(cap), 32'h0000);
    reg_read(2'd0, rd);
    check("R3 slave third word", 32'(rd), 32'h0F0F);

    // R10 abandoned frame
    slave_frame(16'hFFFF, 5, cap);
    reg_read(2'd2, rd);
    check("R10 abort leaves status", 32'(rd), 32'h0);
    reg_read(2'd0, rd);
    check("R10 abort keeps read buffer", 32'(rd), 32'h0F0F);

    // R10 edges with chip select high
    for (int i = 0; i < 16; i++) begin
      repeat (4) @(negedge clk); sclk_i = 1'b1;
      repeat (4) @(negedge clk); sclk_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    reg_read(2'd2, rd);
    check("R10 edges ignored while deselected", 32'(rd), 32'h0);

    report();
  end
endmodule